// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading page-table entries from memory. It takes one translate request at a time and issues one or two reads (three in extended mode) through a single read port with a valid/ready request and a valid response. It then returns either the physical address or a page fault that names the level where the walk stopped. The table root comes from a root-base input, which is sampled when the request is accepted.

In normal mode each entry is 32 bits. A first-level entry either points to a second-level table or, when its large-page flag is set, maps a 4 MB region directly, so the walk ends after one read. Sparse address spaces simply leave a first-level entry non-present, and the walk faults there.

In extended mode, chosen per request, the tree has three levels. Entries are 64 bits and the result is a 36-bit physical address. A generate parameter can remove extended-mode support altogether.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and res_valid is 0.
- R2: In normal mode (req_ext=0), the first read is at root_base[35:12]*4096 + vaddr[31:22]*4, and a second-level read is at entry[31:12]*4096 + vaddr[21:12]*4.
- R3: A present (bit 0 = 1) normal second-level entry ends the walk with res_paddr = {4'b0, entry[31:12], vaddr[11:0]}, res_fault = 0 and res_level = 2.
- R4: A present normal first-level entry with bit 7 = 1 ends the walk after one read, with res_paddr = {4'b0, entry[31:22], vaddr[21:0]} and res_level = 1.
- R5: Bit 7 has no effect in a normal second-level entry or in any extended-mode entry; the walk proceeds as if it were 0.
- R6: In extended mode (req_ext=1), three reads are made at base*4096 + index*8, with indices vaddr[31:30], vaddr[29:21] and vaddr[20:12]. Each next base is entry[35:12], and the result is res_paddr = {entry[35:12], vaddr[11:0]} with res_level = 3.
- R7: An entry with bit 0 = 0 at level L ends the walk with res_fault = 1, res_level = L and res_paddr = 0, and no further reads are issued.
- R8: In normal mode, mem_rsp_data[63:32] is ignored. In extended mode, mem_rsp_data[63:36] is ignored.
- R9: At most one read is outstanding. mem_req_valid and mem_req_addr stay unchanged until mem_req_ready, and no new read is issued before the response arrives.
- R10: req_ready is 1 only while no walk is in progress. res_valid is a one-cycle pulse with no read request alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ext | input | 1 | 1 selects the three-level extended walk |
| root_base | input | 36 | Root table address, bits [11:0] ignored |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 1 | Walk hit a non-present entry |
| res_level | output | 2 | Level of the leaf or of the faulting entry |
| res_paddr | output | 36 | Physical address, zero on fault |

## Verification
The bench places entries whose unused upper data bits hold junk, and entries whose large-page bit is set at levels where it must not count. A design that sign-extends junk or honours the flag in the wrong place would return a wrong frame or stop the walk early. Faults are forced at every level of both walk depths. A walker that kept reading after a non-present entry would show an unexpected address on the read port, and one that reported the wrong level would mismatch res_level. Memory back-pressure and response delay vary from one read to the next. A design that dropped its request before it was accepted, or that treated a stale response as valid, would emit read addresses out of the expected order.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int OFS_W       = 12;
   localparam int PRESENT_BIT = 0;
   localparam int LARGE_BIT   = 7;
   localparam int NORM_ESZ_SH = 2;
   localparam int EXT_ESZ_SH  = 3;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD1   = 3'd1,
      ST_RD2   = 3'd2,
      ST_RD3   = 3'd3,
      ST_DONE  = 3'd4,
      ST_FAULT = 3'd5
   } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W = 32,
   parameter int PA_W = 36,
   localparam int TB_W = PA_W - ptw_pkg::OFS_W
) (
   input  logic [TB_W-1:0] tbase,
   input  logic [VA_W-1:0] vaddr,
   input  logic [1:0]      lvl,
   input  logic            ext,
   output logic [PA_W-1:0] eaddr
);
   import ptw_pkg::*;

   logic [9:0] idx;
   logic [PA_W-1:0] ofs;

   always_comb begin
      idx = '0;
      if (ext) begin
         case (lvl)
            2'd1:    idx = {8'd0, vaddr[31:30]};
            2'd2:    idx = {1'b0, vaddr[29:21]};
            default: idx = {1'b0, vaddr[20:12]};
         endcase
         ofs = PA_W'(idx) << EXT_ESZ_SH;
      end else begin
         if (lvl == 2'd1) idx = vaddr[31:22];
         else             idx = vaddr[21:12];
         ofs = PA_W'(idx) << NORM_ESZ_SH;
      end
      eaddr = {tbase, {OFS_W{1'b0}}} + ofs;
   end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 36,
   parameter int DW     = 64,
   parameter bit EXT_EN = 1'b1,
   localparam int TB_W  = PA_W - ptw_pkg::OFS_W
) (
   input  logic [DW-1:0]   data,
   input  logic            ext,
   input  logic [1:0]      lvl,
   input  logic [VA_W-1:0] vaddr,
   output logic            present,
   output logic            large_hit,
   output logic [TB_W-1:0] next_base,
   output logic [PA_W-1:0] leaf_pa
);
   import ptw_pkg::*;

   logic ext_eff;
   logic [TB_W-1:0] base_norm;
   logic [TB_W-1:0] base_ext;

   generate
      if (EXT_EN) begin : g_ext
         assign ext_eff  = ext;
         assign base_ext = data[PA_W-1:OFS_W];
      end else begin : g_noext
         assign ext_eff  = 1'b0;
         assign base_ext = '0;
      end
   endgenerate

   assign base_norm = TB_W'(data[31:OFS_W]);
   assign present   = data[PRESENT_BIT];
   // the large flag only counts at the first level of a normal walk
   assign large_hit = !ext_eff && (lvl == 2'd1) && data[LARGE_BIT];
   assign next_base = ext_eff ? base_ext : base_norm;

   always_comb begin
      if (large_hit) leaf_pa = PA_W'({data[31:22], vaddr[21:0]});
      else           leaf_pa = {next_base, vaddr[OFS_W-1:0]};
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 36,
   parameter int DW     = 64,
   parameter bit EXT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_ext,
   input  logic [PA_W-1:0] root_base,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_data,
   output logic            res_valid,
   output logic            res_fault,
   output logic [1:0]      res_level,
   output logic [PA_W-1:0] res_paddr
);
   import ptw_pkg::*;
   localparam int TB_W = PA_W - OFS_W;

   generate
      if (VA_W != 32) begin : g_bad_va
         $error("ptw_walker: VA_W must be 32");
      end
      if (PA_W < 32) begin : g_bad_pa
         $error("ptw_walker: PA_W must be at least 32");
      end
      if (DW < PA_W || DW < 32) begin : g_bad_dw
         $error("ptw_walker: DW must hold a full entry");
      end
   endgenerate

   walk_st_e        st_q;
   logic            wait_q;
   logic [VA_W-1:0] va_q;
   logic            ext_q;
   logic [TB_W-1:0] tbase_q;
   logic [PA_W-1:0] pa_q;
   logic [1:0]      lvl_res_q;

   logic [1:0]      lvl;
   logic            reading;
   logic            last_lvl;
   logic            ent_present;
   logic            ent_large;
   logic [TB_W-1:0] ent_base;
   logic [PA_W-1:0] ent_leaf;
   logic [PA_W-1:0] ent_addr;

   always_comb begin
      case (st_q)
         ST_RD1:  lvl = 2'd1;
         ST_RD2:  lvl = 2'd2;
         ST_RD3:  lvl = 2'd3;
         default: lvl = 2'd0;
      endcase
   end

   assign reading  = (st_q == ST_RD1) || (st_q == ST_RD2) || (st_q == ST_RD3);
   assign last_lvl = ext_q ? (lvl == 2'd3) : (lvl == 2'd2);

   ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W)) u_agen (
      .tbase (tbase_q),
      .vaddr (va_q),
      .lvl   (lvl),
      .ext   (ext_q),
      .eaddr (ent_addr)
   );

   ptw_entry_dec #(.VA_W(VA_W), .PA_W(PA_W), .DW(DW), .EXT_EN(EXT_EN)) u_dec (
      .data      (mem_rsp_data),
      .ext       (ext_q),
      .lvl       (lvl),
      .vaddr     (va_q),
      .present   (ent_present),
      .large_hit (ent_large),
      .next_base (ent_base),
      .leaf_pa   (ent_leaf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         wait_q    <= 1'b0;
         va_q      <= '0;
         ext_q     <= 1'b0;
         tbase_q   <= '0;
         pa_q      <= '0;
         lvl_res_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  ext_q   <= EXT_EN ? req_ext : 1'b0;
                  tbase_q <= root_base[PA_W-1:OFS_W];
                  wait_q  <= 1'b0;
                  st_q    <= ST_RD1;
               end
            end
            ST_RD1, ST_RD2, ST_RD3: begin
               if (!wait_q) begin
                  if (mem_req_ready) wait_q <= 1'b1;
               end else if (mem_rsp_valid) begin
                  wait_q <= 1'b0;
                  if (!ent_present) begin
                     pa_q      <= '0;
                     lvl_res_q <= lvl;
                     st_q      <= ST_FAULT;
                  end else if (ent_large || last_lvl) begin
                     pa_q      <= ent_leaf;
                     lvl_res_q <= lvl;
                     st_q      <= ST_DONE;
                  end else begin
                     tbase_q <= ent_base;
                     st_q    <= (st_q == ST_RD1) ? ST_RD2 : ST_RD3;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = reading && !wait_q;
   assign mem_req_addr  = ent_addr;
   assign res_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
   assign res_fault     = (st_q == ST_FAULT);
   assign res_level     = lvl_res_q;
   assign res_paddr     = pa_q;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
   // R9
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);
   // R10
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   // R10
   res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !mem_req_valid && !req_ready);
   // R7
   fault_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> res_level != 2'd0 && res_paddr == '0);
   // R3
   page_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault |-> res_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]);
   // R1
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid && !res_valid);
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_ext = 1'b0;
   logic [35:0] root_base = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [35:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_fault;
   logic [1:0]  res_level;
   logic [35:0] res_paddr;

   always #2.5 clk = ~clk;

   ptw_walker u_ptw_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_ext(req_ext), .root_base(root_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
      .res_level(res_level), .res_paddr(res_paddr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int n_res = 0;
   logic [63:0] tb_mem [logic [35:0]];
   logic [35:0] exp_addr [$];
   logic [35:0] exp_pa [$];
   logic        exp_flt [$];
   logic [1:0]  exp_lvl [$];
   bit          pend = 0;
   int          pend_dly = 0;
   logic [35:0] pend_addr = '0;
   bit          prev_res = 0;
   bit          done = 0;

   task automatic chk(input bit ok, input string req, input logic [35:0] act,
                      input logic [35:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [63:0] rd(input logic [35:0] a);
      if (tb_mem.exists(a)) return tb_mem[a];
      return 64'd0;
   endfunction

   // behavioural walk: expected read addresses and result
   function automatic void model(input logic [31:0] va, input bit ext,
                                 input logic [35:0] root);
      logic [35:0] tb;
      logic [63:0] e;
      int nlev;
      tb = {root[35:12], 12'd0};
      nlev = ext ? 3 : 2;
      for (int l = 1; l <= nlev; l++) begin
         logic [35:0] a;
         int idx;
         if (ext) idx = (l == 1) ? int'(va[31:30]) : (l == 2) ? int'(va[29:21]) : int'(va[20:12]);
         else     idx = (l == 1) ? int'(va[31:22]) : int'(va[21:12]);
         a = tb + 36'(idx * (ext ? 8 : 4));
         exp_addr.push_back(a);
         e = rd(a);
         if (!ext) e[63:32] = 32'd0;
         else      e[63:36] = 28'd0;
         if (!e[0]) begin
            exp_pa.push_back(36'd0); exp_flt.push_back(1'b1); exp_lvl.push_back(2'(l));
            return;
         end
         if (!ext && l == 1 && e[7]) begin
            exp_pa.push_back({4'd0, e[31:22], va[21:0]});
            exp_flt.push_back(1'b0); exp_lvl.push_back(2'd1);
            return;
         end
         tb = {e[35:12], 12'd0};
         if (l == nlev) begin
            exp_pa.push_back({tb[35:12], va[11:0]});
            exp_flt.push_back(1'b0); exp_lvl.push_back(2'(l));
         end
      end
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // memory model and every-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (pend_dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data = rd(pend_addr);
               pend = 0;
            end else pend_dly--;
         end
         mem_req_ready = (cyc % 4 != 1);
         if (mem_req_valid && mem_req_ready) begin
            if (exp_addr.size() == 0)
               chk(0, "R7/R9 unexpected read", mem_req_addr, 36'd0);
            else begin
               logic [35:0] ea;
               ea = exp_addr.pop_front();
               chk(mem_req_addr == ea, "R2/R6 read address", mem_req_addr, ea);
            end
            chk(!pend, "R9 one outstanding", 36'(pend), 36'd0);
            pend = 1; pend_dly = cyc % 3; pend_addr = mem_req_addr;
         end
         if (res_valid) begin
            chk(!prev_res, "R10 result pulse", 36'(prev_res), 36'd0);
            if (exp_pa.size() == 0) chk(0, "R10 spurious result", 36'd1, 36'd0);
            else begin
               logic [35:0] ep; logic ef; logic [1:0] el;
               ep = exp_pa.pop_front(); ef = exp_flt.pop_front(); el = exp_lvl.pop_front();
               chk(res_fault == ef, "R7 fault flag", 36'(res_fault), 36'(ef));
               chk(res_level == el, "R3/R4/R6/R7 level", 36'(res_level), 36'(el));
               chk(res_paddr == ep, "R3/R4/R5/R6/R8 paddr", res_paddr, ep);
               chk(exp_addr.size() == 0, "R7 reads left", 36'(exp_addr.size()), 36'd0);
            end
            n_res++;
         end
         prev_res = res_valid;
      end
   end

   task automatic translate(input logic [31:0] va, input bit ext, input logic [35:0] root);
      int start;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_ext = ext; root_base = root;
      model(va, ext, root);
      start = n_res;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R10 busy ready", 36'(req_ready), 36'd0);
      for (int t = 0; t < 200 && n_res == start; t++) @(negedge clk);
      chk(n_res != start, "R10 walk completes", 36'd0, 36'd1);
   endtask

   initial begin
      for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // normal tables (upper word is junk, R8)
      tb_mem[36'h0_0001_0120] = {32'hDEAD_BEEF, 32'h0002_0001};
      tb_mem[36'h0_0002_0D14] = {32'hFFFF_FFFF, 32'hABCD_E001};
      tb_mem[36'h0_0001_0804] = {32'hC0FF_EE00, 32'h4040_0081};
      tb_mem[36'h0_0002_0D18] = {32'h1234_5678, 32'h5555_5081};
      // extended tables, large bit set in L1 (R5), junk above bit 35
      tb_mem[36'h0_0003_0008] = {28'hABCDEF1, 36'h0_0004_0081};
      tb_mem[36'h0_0004_0018] = {28'h0000000, 36'h0_0005_0001};
      tb_mem[36'h0_0005_0018] = {28'hFFFFFFF, 36'hF_1234_5001};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 req_ready", 36'(req_ready), 36'd1);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 36'(mem_req_valid), 36'd0);
      chk(res_valid == 1'b0, "R1 res_valid", 36'(res_valid), 36'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int rep = 0; rep < 3; rep++) begin
         translate(32'h1234_5678, 1'b0, 36'h0_0001_0000); // R2 R3
         translate(32'h8056_789A, 1'b0, 36'h0_0001_0000); // R4
         translate(32'hC000_0000, 1'b0, 36'h0_0001_0000); // R7 level 1
         translate(32'h1230_0000, 1'b0, 36'h0_0001_0000); // R7 level 2
         translate(32'h1234_6ABC, 1'b0, 36'h0_0001_0FFF); // R5 at level 2
         translate(32'h4060_3234, 1'b1, 36'h0_0003_0000); // R6 R5 R8
         translate(32'h4060_4000, 1'b1, 36'h0_0003_0000); // R7 level 3
         translate(32'h4080_0000, 1'b1, 36'h0_0003_0000); // R7 level 2
         translate(32'hC000_0000, 1'b1, 36'h0_0003_0000); // R7 level 1
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R10 idle after walks", 36'(req_ready), 36'd1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule